// File: doc/BRIEF.md
# Profiling Counter Unit

This block counts things so software can profile code. It holds one cycle counter and four event counters, all 32 bits wide. Each event counter watches one line of an event-strobe input bus, and a per-counter 8-bit select code picks that line. All registers sit behind a small single-cycle port with an address, a write enable, write data and read data. Reads are combinational from the addressed register.

A counter that wraps from all ones to zero sets its own sticky overflow flag. A single interrupt line is raised while any flag is set whose enable bit is also set. To get an interrupt after N events, software preloads a counter with the two's complement of N. The cycle counter can step on every clock, or once every 64 enabled clocks through a 6-bit prescaler.

Register addresses: 0 control, 1 event select, 2 interrupt enable, 3 overflow flags, 4 cycle counter, 5 to 8 event counters 0 to 3.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset every counter, the event-select register, the interrupt-enable register and the overflow flags read zero. The interrupt output is low. The control register reads 0x2A000000.
- R2: Control bit 0 is the global enable and bit 3 selects the divide-by-64 cycle mode. Both read back as written. Bits 1, 2 and 4 to 23 always read zero. Bits 31:24 read the constant 0x2A, whatever is written there.
- R3: Event counter k advances by one on each enabled clock edge where strobe line S is high. S is the code held in event-select bits [8k+7:8k].
- R4: An event counter whose code is 0xFF, or any code of 32 or above, never advances, whatever the strobes do.
- R5: While control bit 0 is clear, no counter advances. Setting the bit again resumes counting from the values held.
- R6: Writing control with bit 1 set clears all four event counters and leaves the cycle counter untouched. Writing control with bit 2 set clears the cycle counter and the prescaler.
- R7: With bit 3 clear, the cycle counter advances on every enabled clock edge. With bit 3 set, it advances once per 64 enabled edges. The prescaler holds its count while counting is disabled.
- R8: A counter that wraps from all ones to zero sets its overflow flag. Bit 0 is the cycle counter and bits 1 to 4 are event counters 0 to 3. The flag stays set until it is cleared.
- R9: A write to the overflow-flag register clears each flag whose written bit is 1. Flags written as 0 are unchanged.
- R10: The interrupt output is high exactly while some overflow flag and its interrupt-enable bit (same bit mapping) are both set.
- R11: A wrap in the same cycle as a write that clears that counter's flag leaves the flag set.
- R12: A direct write to a counter in the same cycle as an increment loads the written value, and that increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| evt_strobe | input | 32 | Event strobe lines, one per event code |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest cases to reach are the same-cycle collisions: a wrap that lands in the very cycle software clears the flag, and a counter write that lands on an increment. The bench first preloads a counter with all ones. It then drives the register write and the matching strobe on the same falling edge, so both meet at one rising edge. The divide-by-64 mode is reached by resetting the prescaler and then holding enable for exactly counted spans of 128, 63 and 2 edges. The last two spans check that the prescaler phase survives a pause.

// File: rtl/pmu_pkg.sv
// Shared constants of the profiling counter unit: register addresses,
// control bit positions, the unused event code and the constant ID field.
package pmu_pkg;
    localparam int REG_DATA_W = 32;
    localparam int REG_ADDR_W = 4;
    localparam int SEL_W      = 8;

    localparam logic [SEL_W-1:0] SEL_NONE = 8'hFF;
    localparam logic [7:0]       UNIT_ID  = 8'h2A;

    // control bit positions
    localparam int CTL_EN    = 0;
    localparam int CTL_EVRST = 1;
    localparam int CTL_CYRST = 2;
    localparam int CTL_DIV   = 3;

    // register addresses
    localparam logic [REG_ADDR_W-1:0] ADR_CTRL     = 4'd0;
    localparam logic [REG_ADDR_W-1:0] ADR_EVSEL    = 4'd1;
    localparam logic [REG_ADDR_W-1:0] ADR_INTEN    = 4'd2;
    localparam logic [REG_ADDR_W-1:0] ADR_OVF      = 4'd3;
    localparam logic [REG_ADDR_W-1:0] ADR_CYC      = 4'd4;
    localparam logic [REG_ADDR_W-1:0] ADR_EVC_BASE = 4'd5;
endpackage

// File: rtl/pmu_counter.sv
// One wrapping counter with a load port and a clear.
// A load wins over a clear, and a clear wins over an increment.
// wrap pulses when an increment that actually takes effect rolls all ones to zero.
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    // counter register with load > clear > increment priority
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (load)  cnt <= load_val;
        else if (clr)   cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    // a roll-over only counts when the increment was not overridden
    assign wrap = inc && !load && !clr && (&cnt);
endmodule

// File: rtl/pmu_prescaler.sv
// Free-running divider for the slow cycle-count mode.
// It steps on every cycle where adv is high, and clr returns it to zero.
// tick marks the step that leaves the all-ones state, i.e. one step in 2**W.
module pmu_prescaler #(
    parameter int W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic tick
);
    logic [W-1:0] q;

    // divider state
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (clr)  q <= '0;
        else if (adv)  q <= q + 1'b1;
    end

    assign tick = adv && !clr && (&q);
endmodule

// File: rtl/pmu_event_sel.sv
// Maps an 8-bit event code onto one strobe line.
// The code 0xFF and any code at or above NUM_STROBES select nothing.
module pmu_event_sel #(
    parameter int NUM_STROBES = 32
) (
    input  logic [pmu_pkg::SEL_W-1:0] code,
    input  logic [NUM_STROBES-1:0]    strobes,
    output logic                      hit
);
    localparam int IDX_W = (NUM_STROBES > 1) ? $clog2(NUM_STROBES) : 1;

    // pick the strobe, guarding out-of-range and unused codes
    always_comb begin
        hit = 1'b0;
        if (code != pmu_pkg::SEL_NONE && int'(code) < NUM_STROBES)
            hit = strobes[code[IDX_W-1:0]];
    end
endmodule

// File: rtl/perf_mon_unit.sv
// Profiling counter unit: one cycle counter and NUM_EVT_CNT event counters
// behind a single-cycle register port, with sticky overflow flags and one interrupt.
// Assumes NUM_EVT_CNT <= 4, so the select codes fit one 32-bit register,
// and CNT_W <= 32.
module perf_mon_unit #(
    parameter int NUM_EVT_CNT = 4,
    parameter int CNT_W       = 32,
    parameter int NUM_STROBES = 32,
    parameter int PRE_W       = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [pmu_pkg::REG_ADDR_W-1:0]   reg_addr,
    input  logic                             reg_we,
    input  logic [pmu_pkg::REG_DATA_W-1:0]   reg_wdata,
    output logic [pmu_pkg::REG_DATA_W-1:0]   reg_rdata,
    input  logic [NUM_STROBES-1:0]           evt_strobe,
    output logic                             irq
);
    import pmu_pkg::*;

    localparam int NFLAG   = NUM_EVT_CNT + 1;
    localparam int EVSEL_W = NUM_EVT_CNT * SEL_W;

    logic                 ctrl_en_q, div_q;
    logic [EVSEL_W-1:0]   evsel_q;
    logic [NFLAG-1:0]     inten_q, ovf_q, wrap_vec, ovf_clr;
    logic [CNT_W-1:0]     cyc_cnt;
    logic [CNT_W-1:0]     evc_q [NUM_EVT_CNT];
    logic [NUM_EVT_CNT*CNT_W-1:0] evc_flat;

    logic ctrl_wr, evc_rst, cyc_rst, cyc_load, cyc_inc, pre_tick;

    assign ctrl_wr  = reg_we && (reg_addr == ADR_CTRL);
    assign evc_rst  = ctrl_wr && reg_wdata[CTL_EVRST];
    assign cyc_rst  = ctrl_wr && reg_wdata[CTL_CYRST];
    assign cyc_load = reg_we && (reg_addr == ADR_CYC);

    // control, select and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en_q <= 1'b0;
            div_q     <= 1'b0;
            evsel_q   <= '0;
            inten_q   <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                ADR_CTRL: begin
                    ctrl_en_q <= reg_wdata[CTL_EN];
                    div_q     <= reg_wdata[CTL_DIV];
                end
                ADR_EVSEL: evsel_q <= reg_wdata[EVSEL_W-1:0];
                ADR_INTEN: inten_q <= reg_wdata[NFLAG-1:0];
                default: ;
            endcase
        end
    end

    pmu_prescaler #(.W(PRE_W)) pre_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cyc_rst),
        .adv  (ctrl_en_q),
        .tick (pre_tick)
    );

    assign cyc_inc = ctrl_en_q && (!div_q || pre_tick);

    pmu_counter #(.W(CNT_W)) cyc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cyc_rst),
        .load    (cyc_load),
        .load_val(reg_wdata[CNT_W-1:0]),
        .inc     (cyc_inc),
        .cnt     (cyc_cnt),
        .wrap    (wrap_vec[0])
    );

    for (genvar k = 0; k < NUM_EVT_CNT; k++) begin : g_evc
        logic hit, load;

        assign load = reg_we && (reg_addr == REG_ADDR_W'(int'(ADR_EVC_BASE) + k));

        pmu_event_sel #(.NUM_STROBES(NUM_STROBES)) sel_i (
            .code   (evsel_q[k*SEL_W +: SEL_W]),
            .strobes(evt_strobe),
            .hit    (hit)
        );

        pmu_counter #(.W(CNT_W)) cnt_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (evc_rst),
            .load    (load),
            .load_val(reg_wdata[CNT_W-1:0]),
            .inc     (ctrl_en_q && hit),
            .cnt     (evc_q[k]),
            .wrap    (wrap_vec[k+1])
        );

        assign evc_flat[k*CNT_W +: CNT_W] = evc_q[k];
    end

    assign ovf_clr = (reg_we && reg_addr == ADR_OVF) ? reg_wdata[NFLAG-1:0] : '0;

    // sticky overflow flags: a new wrap beats a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= '0;
        else        ovf_q <= (ovf_q & ~ovf_clr) | wrap_vec;
    end

    assign irq = |(ovf_q & inten_q);

    // combinational read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_CTRL: begin
                reg_rdata[31:24]   = UNIT_ID;
                reg_rdata[CTL_EN]  = ctrl_en_q;
                reg_rdata[CTL_DIV] = div_q;
            end
            ADR_EVSEL: reg_rdata[EVSEL_W-1:0] = evsel_q;
            ADR_INTEN: reg_rdata[NFLAG-1:0]   = inten_q;
            ADR_OVF:   reg_rdata[NFLAG-1:0]   = ovf_q;
            ADR_CYC:   reg_rdata[CNT_W-1:0]   = cyc_cnt;
            default: begin
                for (int k = 0; k < NUM_EVT_CNT; k++)
                    if (reg_addr == REG_ADDR_W'(int'(ADR_EVC_BASE) + k))
                        reg_rdata[CNT_W-1:0] = evc_q[k];
            end
        endcase
    end
endmodule

// File: rtl/pmu_checker.sv
// Temporal checks on the profiling counter unit, attached by bind.
// It watches the register port, the interrupt and the held counter state.
module pmu_checker #(
    parameter int NUM_EVT_CNT = 4,
    parameter int CNT_W       = 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [pmu_pkg::REG_ADDR_W-1:0] reg_addr,
    input logic                           reg_we,
    input logic [pmu_pkg::REG_DATA_W-1:0] reg_wdata,
    input logic [pmu_pkg::REG_DATA_W-1:0] reg_rdata,
    input logic                           irq,
    input logic                           ctrl_en,
    input logic [NUM_EVT_CNT:0]           ovf,
    input logic [NUM_EVT_CNT:0]           inten,
    input logic [CNT_W-1:0]               cyc,
    input logic [NUM_EVT_CNT*CNT_W-1:0]   evc
);
    import pmu_pkg::*;

    // R2
    ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_CTRL) |-> (reg_rdata[23:4] == '0 && reg_rdata[2:1] == 2'b00));

    // R5
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !reg_we) |=> ($stable(cyc) && $stable(evc)));

    // R6
    cyc_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADR_CTRL && reg_wdata[CTL_CYRST]) |=> (cyc == '0));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == ADR_OVF) |=> ((ovf & $past(ovf)) == $past(ovf)));

    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inten == '0) |-> !irq);

    // R12
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADR_EVC_BASE) |=> (evc[CNT_W-1:0] == $past(reg_wdata[CNT_W-1:0])));
endmodule

bind perf_mon_unit pmu_checker #(
    .NUM_EVT_CNT(NUM_EVT_CNT),
    .CNT_W      (CNT_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq      (irq),
    .ctrl_en  (ctrl_en_q),
    .ovf      (ovf_q),
    .inten    (inten_q),
    .cyc      (cyc_cnt),
    .evc      (evc_flat)
);

// File: tb/perf_mon_unit_tb.sv
`timescale 1ns/1ps
// Directed bench for the profiling counter unit. There is one task per scenario.
module perf_mon_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] evt_strobe = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    localparam logic [3:0] A_CTRL = 4'd0, A_EVSEL = 4'd1, A_INTEN = 4'd2, A_OVF = 4'd3,
                           A_CYC = 4'd4, A_E0 = 4'd5, A_E1 = 4'd6, A_E2 = 4'd7, A_E3 = 4'd8;
    localparam logic [31:0] S2 = 32'h4, S3 = 32'h8, S5 = 32'h20;

    always #4 clk = ~clk;

    perf_mon_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_strobe(evt_strobe), .irq(irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b0;
        #1 v = reg_rdata;
    endtask

    task automatic expect_reg(input string req, input string what, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, what, v, exp);
    endtask

    task automatic expect_irq(input string req, input logic exp);
        @(negedge clk);
        #1 check(req, "irq", {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic pulse(input logic [31:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            evt_strobe = m;
        end
        @(negedge clk);
        evt_strobe = '0;
    endtask

    task automatic t_reset;
        expect_reg("R1", "ctrl", A_CTRL, 32'h2A00_0000);
        for (int a = 1; a <= 8; a++) expect_reg("R1", "reg", 4'(a), 32'h0);
        expect_irq("R1", 1'b0);
    endtask

    task automatic t_count;
        wr(A_EVSEL, 32'hFF03_0502);
        expect_reg("R3", "evsel readback", A_EVSEL, 32'hFF03_0502);
        wr(A_CTRL, 32'h1);
        pulse(S2 | S5, 10);
        pulse(S3 | S5, 4);
        wr(A_CTRL, 32'h0);
        expect_reg("R3", "cnt0", A_E0, 32'd10);
        expect_reg("R3", "cnt1", A_E1, 32'd14);
        expect_reg("R3", "cnt2", A_E2, 32'd4);
        expect_reg("R4", "cnt3 code FF", A_E3, 32'd0);
    endtask

    task automatic t_enable;
        pulse(32'hFFFF_FFFF, 5);
        expect_reg("R5", "cnt0 frozen", A_E0, 32'd10);
        expect_reg("R5", "cnt1 frozen", A_E1, 32'd14);
        wr(A_EVSEL, 32'h4003_0502);
        wr(A_CTRL, 32'h1);
        pulse(32'hFFFF_FFFF, 2);
        wr(A_CTRL, 32'h0);
        expect_reg("R5", "cnt0 resumed", A_E0, 32'd12);
        expect_reg("R5", "cnt2 resumed", A_E2, 32'd6);
        expect_reg("R4", "cnt3 code 0x40", A_E3, 32'd0);
    endtask

    task automatic t_evreset;
        logic [31:0] cyc0;
        rd(A_CYC, cyc0);
        wr(A_CTRL, 32'h2);
        expect_reg("R6", "cnt0 cleared", A_E0, 32'd0);
        expect_reg("R6", "cnt1 cleared", A_E1, 32'd0);
        expect_reg("R6", "cnt2 cleared", A_E2, 32'd0);
        expect_reg("R6", "cycle untouched", A_CYC, cyc0);
    endtask

    task automatic t_cycle;
        wr(A_CTRL, 32'h4);
        expect_reg("R6", "cycle cleared", A_CYC, 32'd0);
        wr(A_CTRL, 32'h1);
        repeat (20) @(negedge clk);
        wr(A_CTRL, 32'h0);
        expect_reg("R7", "cycle full rate", A_CYC, 32'd22);
        wr(A_CTRL, 32'hC);
        wr(A_CTRL, 32'h9);
        repeat (126) @(negedge clk);
        wr(A_CTRL, 32'h8);
        expect_reg("R7", "div64 after 128", A_CYC, 32'd2);
        wr(A_CTRL, 32'h9);
        repeat (61) @(negedge clk);
        wr(A_CTRL, 32'h8);
        expect_reg("R7", "div64 after 63 more", A_CYC, 32'd2);
        wr(A_CTRL, 32'h9);
        wr(A_CTRL, 32'h8);
        expect_reg("R7", "div64 phase kept", A_CYC, 32'd3);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_overflow;
        wr(A_EVSEL, 32'hFF03_0502);
        wr(A_E1, 32'hFFFF_FFFD);
        wr(A_CTRL, 32'h1);
        pulse(S5, 3);
        wr(A_CTRL, 32'h0);
        expect_reg("R8", "cnt1 wrapped", A_E1, 32'd0);
        expect_reg("R8", "flag cnt1", A_OVF, 32'h04);
        expect_irq("R10", 1'b0);
        wr(A_INTEN, 32'h04);
        expect_irq("R10", 1'b1);
        wr(A_OVF, 32'h1B);
        expect_reg("R9", "zeros keep flag", A_OVF, 32'h04);
        wr(A_OVF, 32'h04);
        expect_reg("R9", "one clears flag", A_OVF, 32'h00);
        expect_irq("R10", 1'b0);
        wr(A_CYC, 32'hFFFF_FFF0);
        wr(A_CTRL, 32'h1);
        repeat (20) @(negedge clk);
        wr(A_CTRL, 32'h0);
        expect_reg("R8", "cycle wrapped", A_CYC, 32'h6);
        expect_reg("R8", "flag cycle", A_OVF, 32'h01);
        wr(A_OVF, 32'h01);
    endtask

    task automatic t_collide;
        wr(A_E0, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h1);
        pulse(S2, 1);
        wr(A_E0, 32'hFFFF_FFFF);
        @(negedge clk);
        reg_addr = A_OVF; reg_wdata = 32'h02; reg_we = 1'b1; evt_strobe = S2;
        @(negedge clk);
        reg_we = 1'b0; evt_strobe = '0;
        wr(A_CTRL, 32'h0);
        expect_reg("R11", "flag survives clear", A_OVF, 32'h02);
        expect_reg("R11", "cnt0 wrapped", A_E0, 32'd0);
        wr(A_OVF, 32'h02);
    endtask

    task automatic t_priority;
        wr(A_CTRL, 32'h1);
        @(negedge clk);
        reg_addr = A_E2; reg_wdata = 32'd100; reg_we = 1'b1; evt_strobe = S3;
        @(negedge clk);
        reg_we = 1'b0; evt_strobe = '0;
        expect_reg("R12", "write beats increment", A_E2, 32'd100);
        pulse(S3, 1);
        wr(A_CTRL, 32'h0);
        expect_reg("R12", "counts after write", A_E2, 32'd101);
    endtask

    task automatic t_ctrl_bits;
        wr(A_CTRL, 32'hFFFF_FF08);
        expect_reg("R2", "ctrl readback", A_CTRL, 32'h2A00_0008);
        wr(A_CTRL, 32'h0);
        expect_reg("R2", "ctrl cleared", A_CTRL, 32'h2A00_0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_enable();
        t_evreset();
        t_cycle();
        t_overflow();
        t_collide();
        t_priority();
        t_ctrl_bits();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule